// File: doc/BRIEF.md
# I2C Bus Clock Prescaler

This block derives the bit timing of an I2C master from the core clock. A single 8-bit configuration word holds a 4-bit linear factor, a 3-bit exponent and one mode bit. The divider is two counters in series: a linear stage that counts to the linear factor, and a power-of-two stage. Together they produce a one-cycle sample tick. Ten ticks make one SCL period.

A ten-step phase counter advances on every tick. SCL is low for the first five phases and high for the last five. The counter also emits a data-change strobe in the middle of the low half and a sample strobe in the middle of the high half. The master's shifter uses these strobes.

The mode bit chooses the exponent convention. In one mode the power-of-two stage divides by two to the exponent plus one. In the other it divides by two to the exponent. A slave may stretch the clock. While the block has released SCL (high phase) and the bus is still sensed low, the divider holds its count. Writing the configuration word restarts the divider and the phase from zero.

Top module: `sclk_prescaler`

## Requirements
- R1: After reset, `tick`, `scl_out`, `chg_stb` and `smp_stb` are 0, and the configuration is linear factor 0, exponent 0, default mode. The first tick appears in the second cycle after the last reset edge.
- R2: With `cfg_wdata[7]`=0, `cfg_wdata[2:0]`=N and `cfg_wdata[6:3]`=M, `tick` is a one-cycle pulse every (M+1)·2^(N+1) core cycles. This covers 2 to 4096 cycles.
- R3: With `cfg_wdata[7]`=1, the tick period is (M+1)·2^N core cycles, which covers 1 to 2048. With M=N=0, `tick` is high on every cycle.
- R4: A configuration write clears both divider stages and the phase. In the cycle after the write edge, `tick`, both strobes and `scl_out` are 0. The first tick under the new setting comes exactly one new period after the write edge. This holds even when the write edge is also a terminal-count edge.
- R5: `scl_out` changes only in a tick cycle or after a write. After a tick, `scl_out` is 0 when the new phase is 0 to 4 and 1 when it is 5 to 9. The phase wraps from 9 to 0, so one SCL period is 10 ticks.
- R6: `chg_stb` is high only in the tick cycle that enters phase 2. `smp_stb` is high only in the tick cycle that enters phase 7. The two strobes are never high together.
- R7: While `scl_out`=1 and `bus_scl_low`=1, no tick occurs and the divider holds its count. After release, the rest of the interval completes unchanged.
- R8: `bus_scl_low`=1 while `scl_out`=0 has no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Exponent [2:0], linear factor [6:3], mode [7] |
| bus_scl_low | input | 1 | SCL line sensed low on the bus |
| tick | output | 1 | Sample tick, ten per SCL period |
| scl_out | output | 1 | SCL level the master drives (0 low, 1 released) |
| chg_stb | output | 1 | Data-change strobe, middle of low half |
| smp_stb | output | 1 | Sample strobe, middle of high half |

## Verification
A configuration write can land in the same cycle as a terminal count. The bench waits for a tick, then times a write so that its edge falls exactly one period later. It then checks that the tick is suppressed, that `scl_out` returns low, and that the next tick arrives one new period afterwards.

A stretch request can also start in the very cycle SCL is released. The bench raises `bus_scl_low` in that tick cycle and expects no further ticks until release. It then expects the held interval to complete with its original length.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic {
    EXP_PLUS_ONE = 1'b0,
    EXP_PLAIN    = 1'b1
  } exp_mode_e;

  // phase index of the middle of the low half of an SCL period
  function automatic int unsigned low_mid_phase(input int unsigned ticks);
    return ticks / 4;
  endfunction

  // phase index of the middle of the high half of an SCL period
  function automatic int unsigned high_mid_phase(input int unsigned ticks);
    return ticks / 2 + ticks / 4;
  endfunction

endpackage

// File: rtl/sclk_lin_stage.sv
module sclk_lin_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == lim_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_pow_stage.sv
module sclk_pow_stage
  import sclk_pkg::*;
#(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           adv,
  input  logic [N_W-1:0] n_i,
  input  exp_mode_e      mode_i,
  output logic           wrap_o
);

  localparam int CW = 1 << N_W;
  localparam int EW = N_W + 1;

  logic [EW-1:0] exp_w;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q;

  assign exp_w = (mode_i == EXP_PLAIN) ? {1'b0, n_i} : {1'b0, n_i} + 1'b1;

  // terminal value is 2^exp - 1: one bit set per exponent step
  for (genvar i = 0; i < CW; i++) begin : g_lim
    assign lim[i] = (exp_w > EW'(i));
  end

  assign wrap_o = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
  import sclk_pkg::*;
#(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic tick_o,
  output logic scl_o,
  output logic chg_o,
  output logic smp_o
);

  localparam int PH_W = $clog2(TICKS);
  localparam int HALF = TICKS / 2;
  localparam int CHG  = int'(low_mid_phase(TICKS));
  localparam int SMP  = int'(high_mid_phase(TICKS));

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nx;

  assign ph_nx = (ph_q == PH_W'(TICKS - 1)) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q   <= '0;
      tick_o <= 1'b0;
      scl_o  <= 1'b0;
      chg_o  <= 1'b0;
      smp_o  <= 1'b0;
    end else if (step) begin
      ph_q   <= ph_nx;
      tick_o <= 1'b1;
      scl_o  <= (ph_nx >= PH_W'(HALF));
      chg_o  <= (ph_nx == PH_W'(CHG));
      smp_o  <= (ph_nx == PH_W'(SMP));
    end else begin
      tick_o <= 1'b0;
      chg_o  <= 1'b0;
      smp_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_pkg::*;
#(
  parameter int M_W           = 4,
  parameter int N_W           = 3,
  parameter int TICKS_PER_SCL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [M_W+N_W:0] cfg_wdata,
  input  logic             bus_scl_low,
  output logic             tick,
  output logic             scl_out,
  output logic             chg_stb,
  output logic             smp_stb
);

  localparam int MODE_BIT = M_W + N_W;

  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  exp_mode_e      mode_q;

  logic run;
  logic lin_wrap;
  logic pow_wrap;
  logic step;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q    <= '0;
      n_q    <= '0;
      mode_q <= EXP_PLUS_ONE;
    end else if (cfg_we) begin
      m_q    <= cfg_wdata[MODE_BIT-1:N_W];
      n_q    <= cfg_wdata[N_W-1:0];
      mode_q <= exp_mode_e'(cfg_wdata[MODE_BIT]);
    end
  end

  // released SCL still sensed low: slave is stretching, hold the divider
  assign run  = ~(scl_out & bus_scl_low);
  assign step = run & lin_wrap & pow_wrap;

  sclk_lin_stage #(.W(M_W)) u_lin (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_we),
    .adv    (run),
    .lim_i  (m_q),
    .wrap_o (lin_wrap)
  );

  sclk_pow_stage #(.N_W(N_W)) u_pow (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_we),
    .adv    (run & lin_wrap),
    .n_i    (n_q),
    .mode_i (mode_q),
    .wrap_o (pow_wrap)
  );

  sclk_phase_gen #(.TICKS(TICKS_PER_SCL)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_we),
    .step   (step),
    .tick_o (tick),
    .scl_o  (scl_out),
    .chg_o  (chg_stb),
    .smp_o  (smp_stb)
  );

endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk #(
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_we,
  input logic           bus_scl_low,
  input logic           tick,
  input logic           scl_out,
  input logic           chg_stb,
  input logic           smp_stb,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_val,
  input logic           alt
);

  localparam int GAP_W = M_W + (1 << N_W) + 1;

  logic [N_W:0]       ex;
  logic [GAP_W-1:0]   period;
  logic [GAP_W-1:0]   gap_q;
  logic [GAP_W-1:0]   base;
  logic               frz;

  assign ex     = alt ? {1'b0, n_val} : {1'b0, n_val} + 1'b1;
  assign period = (GAP_W'(m_val) + GAP_W'(1)) << ex;
  assign frz    = scl_out & bus_scl_low;
  assign base   = tick ? '0 : gap_q;

  always_ff @(posedge clk) begin
    if (rst || cfg_we) gap_q <= '0;
    else               gap_q <= frz ? base : base + 1'b1;
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap_q == period);

  // R5
  scl_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !$past(cfg_we)) |-> $stable(scl_out));

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chg_stb, smp_stb}));

  // R6
  strobe_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_stb || smp_stb) |-> tick);

  // R6
  strobe_half_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_stb |-> !scl_out) and (smp_stb |-> scl_out));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_out && bus_scl_low && !cfg_we) |=> !tick);

endmodule

bind sclk_prescaler sclk_prescaler_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .bus_scl_low (bus_scl_low),
  .tick        (tick),
  .scl_out     (scl_out),
  .chg_stb     (chg_stb),
  .smp_stb     (smp_stb),
  .m_val       (m_q),
  .n_val       (n_q),
  .alt         (mode_q)
);

// File: tb/sim_sclk_prescaler.sv
module sim_sclk_prescaler;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       bus_scl_low;
  logic       tick, scl_out, chg_stb, smp_stb;

  always #5 clk = ~clk;

  sclk_prescaler u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_scl_low(bus_scl_low), .tick(tick), .scl_out(scl_out),
    .chg_stb(chg_stb), .smp_stb(smp_stb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;
  int wd = 0;

  // behavioural reference: one flat counter per tick period
  int e_per = 2;
  int e_cnt = 0;
  int e_ph = 0;
  bit e_tick = 0, e_scl = 0, e_chg = 0, e_smp = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_per = 2; e_cnt = 0; e_ph = 0;
      e_tick = 0; e_scl = 0; e_chg = 0; e_smp = 0;
    end else if (cfg_we) begin
      e_per = (int'(cfg_wdata[6:3]) + 1) *
              (1 << (cfg_wdata[7] ? int'(cfg_wdata[2:0]) : int'(cfg_wdata[2:0]) + 1));
      e_cnt = 0; e_ph = 0;
      e_tick = 0; e_scl = 0; e_chg = 0; e_smp = 0;
    end else if (e_scl && bus_scl_low) begin
      e_tick = 0; e_chg = 0; e_smp = 0;
    end else if (e_cnt == e_per - 1) begin
      e_cnt = 0;
      e_ph = (e_ph + 1) % 10;
      e_tick = 1;
      e_scl = (e_ph >= 5);
      e_chg = (e_ph == 2);
      e_smp = (e_ph == 7);
    end else begin
      e_cnt++;
      e_tick = 0; e_chg = 0; e_smp = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R2/R3 tick vs model", 32'(tick), 32'(e_tick));
      check("R5 scl_out vs model", 32'(scl_out), 32'(e_scl));
      check("R6 chg_stb vs model", 32'(chg_stb), 32'(e_chg));
      check("R6 smp_stb vs model", 32'(smp_stb), 32'(e_smp));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
      finish_run();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic gap_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tick !== 1'b1);
  endtask

  int g;
  int cnt;

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; bus_scl_low = 1'b0;
    @(posedge clk);
    cmp_on = 1;
    cyc(3);
    // R1 reset state
    check("R1 tick after reset", 32'(tick), 0);
    check("R1 scl_out after reset", 32'(scl_out), 0);
    check("R1 chg_stb after reset", 32'(chg_stb), 0);
    check("R1 smp_stb after reset", 32'(smp_stb), 0);
    rst = 1'b0;
    gap_to_tick(g); check("R1 first tick with default config", g, 2);
    gap_to_tick(g); check("R2 default M0 N0 period", g, 2);

    // R2: M=2 N=1 default mode
    wr(8'h11);
    gap_to_tick(g); check("R4 first tick after write", g, 12);
    gap_to_tick(g); check("R2 M2 N1 period", g, 12);

    // R3: alternate exponent
    wr(8'h91);
    gap_to_tick(g); check("R3 M2 N1 alt first", g, 6);
    gap_to_tick(g); check("R3 M2 N1 alt period", g, 6);
    wr(8'h80);
    gap_to_tick(g); check("R3 M0 N0 alt first", g, 1);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tick === 1'b1) cnt++;
    end
    check("R3 tick held high for divide by one", cnt, 6);

    // R4: write edge coinciding with a terminal edge
    wr(8'h91);
    gap_to_tick(g);
    cyc(5);
    wr(8'h19);
    check("R4 tick cleared by write on terminal edge", 32'(tick), 0);
    check("R4 scl_out cleared by write", 32'(scl_out), 0);
    gap_to_tick(g); check("R4 new period after coincident write", g, 16);

    // R5 / R6 phase placement, P=2
    wr(8'h00);
    for (int k = 1; k <= 10; k++) begin
      gap_to_tick(g);
      check("R5 scl level per phase", 32'(scl_out), (k % 10 >= 5) ? 1 : 0);
      check("R6 chg strobe at phase 2", 32'(chg_stb), (k == 2) ? 1 : 0);
      check("R6 smp strobe at phase 7", 32'(smp_stb), (k == 7) ? 1 : 0);
    end

    // R7 stretch while released
    wr(8'h00);
    do @(negedge clk); while (scl_out !== 1'b1);
    bus_scl_low = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick === 1'b1) cnt++;
    end
    check("R7 no tick while stretched", cnt, 0);
    check("R7 scl stays released while stretched", 32'(scl_out), 1);
    bus_scl_low = 1'b0;
    gap_to_tick(g); check("R7 interval resumes after release", g, 2);

    // R8 bus low during low half has no effect
    wr(8'h91);
    bus_scl_low = 1'b1;
    gap_to_tick(g); check("R8 low-half bus low, first interval", g, 6);
    gap_to_tick(g); check("R8 low-half bus low, second interval", g, 6);
    bus_scl_low = 1'b0;

    // boundary settings
    wr(8'h7F);
    gap_to_tick(g); check("R2 M15 N7 default period", g, 4096);
    wr(8'hFF);
    gap_to_tick(g); check("R3 M15 N7 alt period", g, 2048);

    cyc(2);
    finish_run();
  end

endmodule